// File: doc/BRIEF.md
# Core-Voltage Start-Up Sequencer

This block governs how a core-voltage regulator comes up after its enable input rises. It owns the internal target voltage code that the regulator loop follows. On enable it takes a snapshot of a boot code supplied on a configuration input. It then walks the target upward from a fixed off code, one code per step interval, until the target reaches the boot code.

Once the boot level is reached, the target is held there for a fixed number of cycles. At the end of that hold the active-low clock-enable output is driven low. From the following cycle on, the target follows the external voltage-code inputs with one register of latency. Before that point those inputs have no effect.

A further fixed number of cycles after clock enable falls, power-good rises. Dropping the enable input at any time sends the sequencer back to idle on the next clock edge.

Top module: `core_vid_startup`

## Requirements
- R1: Out of reset, and in every cycle while idle with `en` low, `target_vid` equals OFF_CODE, `clk_en_n` is 1 and `pwr_good` is 0.
- R2: On the first edge that samples `en` high, the ramp starts with the target at OFF_CODE. The target then rises by exactly one code every STEP_CYC cycles. Counting the start edge as edge 1, the k-th increment lands on edge 1 + k*STEP_CYC.
- R3: `boot_code` is captured on the edge that starts the ramp. Later changes to it have no effect on the sequence that is running.
- R4: A boot code equal to or below OFF_CODE produces no increments. The hold stage begins on the edge after the ramp starts.
- R5: The hold stage begins one edge after the target reaches the boot code. The target stays at the boot code for BOOT_CYC cycles, and then `clk_en_n` goes low on the same edge that ends the hold.
- R6: While `clk_en_n` is 1, `ext_vid` has no effect on `target_vid`.
- R7: On every edge after the first one at which `clk_en_n` is already 0 (with `en` still high), `target_vid` takes the `ext_vid` value sampled on that edge.
- R8: `pwr_good` rises exactly PG_CYC edges after the edge on which `clk_en_n` fell. It stays high for as long as `en` stays high.
- R9: When `en` is sampled low in any stage, the next edge restores the R1 values. A later rising `en` runs the whole sequence again.
- R10: `pwr_good` is never 1 while `clk_en_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Regulator enable; high starts and keeps the sequence |
| boot_code | input | VID_W | Boot voltage code, sampled when the ramp starts |
| ext_vid | input | VID_W | External voltage code, honoured once clock enable is low |
| target_vid | output | VID_W | Registered target voltage code for the regulator loop |
| clk_en_n | output | 1 | Active-low clock enable, low from the end of the boot hold |
| pwr_good | output | 1 | Power-good, high from PG_CYC cycles after clock enable falls |

## Verification
A wrong stage or a miscounted timer shows up at the ports within one step interval. It appears as a target increment on the wrong edge, or as `clk_en_n` or `pwr_good` moving one or more cycles early or late. The bench therefore compares all three outputs on every edge against an edge-indexed closed-form model.

A leak of `ext_vid` before clock enable shows on the very next edge. The bench drives `ext_vid` with a pattern that changes every cycle, so any leak appears as a target jump. A missing boot-code capture is exposed by changing `boot_code` mid-ramp and watching where the ramp stops. A stale return to idle is exposed by dropping `en` in the ramp and in the power-good wait.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RAMP,
    ST_BOOT_HOLD,
    ST_WAIT_PG,
    ST_RUN
  } seq_state_e;

  typedef enum logic [1:0] {
    TGT_KEEP,
    TGT_CLEAR,
    TGT_STEP,
    TGT_TRACK
  } tgt_op_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          hit
);

  logic [CW-1:0] cnt;

  // the count wraps to zero on the cycle it reaches the limit
  assign hit = (cnt == (limit - CW'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || hit) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/pwrseq_target.sv
module pwrseq_target
  import pwrseq_pkg::*;
#(
  parameter int VID_W    = 7,
  parameter int OFF_CODE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tgt_op_e          op,
  input  logic [VID_W-1:0] ext_vid,
  output logic [VID_W-1:0] target
);

  localparam logic [VID_W-1:0] OFF_V = VID_W'(OFF_CODE);

  function automatic logic [VID_W-1:0] step_up(input logic [VID_W-1:0] code);
    return (&code) ? code : code + VID_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target <= OFF_V;
    end else begin
      case (op)
        TGT_CLEAR: target <= OFF_V;
        TGT_STEP:  target <= step_up(target);
        TGT_TRACK: target <= ext_vid;
        default:   target <= target;
      endcase
    end
  end

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int CW       = 8,
  parameter int STEP_CYC = 4,
  parameter int BOOT_CYC = 16,
  parameter int PG_CYC   = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          reached,
  input  logic          hit,
  output seq_state_e    state,
  output logic          tmr_clr,
  output logic [CW-1:0] limit,
  output tgt_op_e       op,
  output logic          latch_boot,
  output logic          clk_en_n,
  output logic          pwr_good
);

  seq_state_e nxt;

  assign latch_boot = en && (state == ST_IDLE);

  always_comb begin
    case (state)
      ST_BOOT_HOLD: limit = CW'(BOOT_CYC);
      ST_WAIT_PG:   limit = CW'(PG_CYC);
      default:      limit = CW'(STEP_CYC);
    endcase
  end

  always_comb begin
    nxt     = state;
    tmr_clr = 1'b0;
    op      = TGT_KEEP;
    if (!en) begin
      nxt     = ST_IDLE;
      tmr_clr = 1'b1;
      op      = TGT_CLEAR;
    end else begin
      case (state)
        ST_IDLE: begin
          nxt     = ST_RAMP;
          tmr_clr = 1'b1;
          op      = TGT_CLEAR;
        end
        ST_RAMP: begin
          if (reached) begin
            nxt     = ST_BOOT_HOLD;
            tmr_clr = 1'b1;
          end else if (hit) begin
            op = TGT_STEP;
          end
        end
        ST_BOOT_HOLD: begin
          if (hit) nxt = ST_WAIT_PG;
        end
        ST_WAIT_PG: begin
          op = TGT_TRACK;
          if (hit) nxt = ST_RUN;
        end
        ST_RUN: begin
          op      = TGT_TRACK;
          tmr_clr = 1'b1;
        end
        default: begin
          nxt     = ST_IDLE;
          tmr_clr = 1'b1;
          op      = TGT_CLEAR;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      clk_en_n <= 1'b1;
      pwr_good <= 1'b0;
    end else begin
      state    <= nxt;
      clk_en_n <= !((nxt == ST_WAIT_PG) || (nxt == ST_RUN));
      pwr_good <= (nxt == ST_RUN);
    end
  end

endmodule

// File: rtl/core_vid_startup.sv
module core_vid_startup
  import pwrseq_pkg::*;
#(
  parameter int VID_W    = 7,
  parameter int OFF_CODE = 0,
  parameter int STEP_CYC = 4,
  parameter int BOOT_CYC = 18000,
  parameter int PG_CYC   = 60000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [VID_W-1:0] boot_code,
  input  logic [VID_W-1:0] ext_vid,
  output logic [VID_W-1:0] target_vid,
  output logic             clk_en_n,
  output logic             pwr_good
);

  localparam int unsigned MAX_CYC = max3(STEP_CYC, BOOT_CYC, PG_CYC);
  localparam int CW = $clog2(MAX_CYC + 1);
  localparam logic [VID_W-1:0] OFF_V = VID_W'(OFF_CODE);

  function automatic logic [VID_W-1:0] clamp_boot(input logic [VID_W-1:0] code);
    return (code < OFF_V) ? OFF_V : code;
  endfunction

  seq_state_e       state;
  tgt_op_e          op;
  logic             tmr_clr;
  logic             hit;
  logic [CW-1:0]    limit;
  logic             latch_boot;
  logic [VID_W-1:0] boot_q;
  logic [VID_W-1:0] boot_eff;
  logic             reached;
  logic             ramp_active;

  assign boot_eff    = clamp_boot(boot_q);
  assign reached     = (target_vid >= boot_eff);
  assign ramp_active = (state == ST_RAMP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= OFF_V;
    end else if (latch_boot) begin
      boot_q <= boot_code;
    end
  end

  pwrseq_ctrl #(
    .CW(CW), .STEP_CYC(STEP_CYC), .BOOT_CYC(BOOT_CYC), .PG_CYC(PG_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .reached(reached), .hit(hit),
    .state(state), .tmr_clr(tmr_clr), .limit(limit), .op(op),
    .latch_boot(latch_boot), .clk_en_n(clk_en_n), .pwr_good(pwr_good)
  );

  pwrseq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .limit(limit), .hit(hit)
  );

  pwrseq_target #(.VID_W(VID_W), .OFF_CODE(OFF_CODE)) u_target (
    .clk(clk), .rst_n(rst_n), .op(op), .ext_vid(ext_vid), .target(target_vid)
  );

endmodule

// File: rtl/core_vid_startup_chk.sv
module core_vid_startup_chk #(
  parameter int VID_W    = 7,
  parameter int OFF_CODE = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [VID_W-1:0] ext_vid,
  input logic [VID_W-1:0] target_vid,
  input logic             clk_en_n,
  input logic             pwr_good,
  input logic [VID_W-1:0] boot_eff,
  input logic             ramp_active
);

  // R1
  idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (target_vid == VID_W'(OFF_CODE)) && clk_en_n && !pwr_good);

  // R2
  ramp_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_active && en) |=> ((target_vid - $past(target_vid)) <= VID_W'(1)));

  // R5
  clken_at_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en_n) |-> (target_vid == boot_eff));

  // R6
  hold_before_clken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en_n) |-> $stable(target_vid));

  // R7
  track_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clk_en_n) |=> (target_vid == $past(ext_vid)));

  // R8
  pg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pwr_good) |=> pwr_good);

  // R10
  pg_needs_clken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_good |-> !clk_en_n);

endmodule

bind core_vid_startup core_vid_startup_chk #(.VID_W(VID_W), .OFF_CODE(OFF_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .ext_vid(ext_vid), .target_vid(target_vid),
  .clk_en_n(clk_en_n), .pwr_good(pwr_good), .boot_eff(boot_eff),
  .ramp_active(ramp_active)
);

// File: tb/core_vid_startup_bench.sv
module core_vid_startup_bench;

  localparam int W    = 7;
  localparam int OFF  = 4;
  localparam int STEP = 3;
  localparam int HOLD = 10;
  localparam int PG   = 25;

  typedef struct {
    logic [W-1:0] tgt;
    logic         cen;
    logic         pg;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [W-1:0] boot_code = '0;
  logic [W-1:0] ext_vid = '0;
  logic [W-1:0] target_vid;
  logic         clk_en_n;
  logic         pwr_good;

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  core_vid_startup #(
    .VID_W(W), .OFF_CODE(OFF), .STEP_CYC(STEP), .BOOT_CYC(HOLD), .PG_CYC(PG)
  ) u_core_vid_startup (
    .clk(clk), .rst_n(rst_n), .en(en), .boot_code(boot_code), .ext_vid(ext_vid),
    .target_vid(target_vid), .clk_en_n(clk_en_n), .pwr_good(pwr_good)
  );

  function automatic logic [W-1:0] ext_pat(input int k);
    return W'((k * 37 + 11) % 128);
  endfunction

  function automatic int steps_for(input int boot);
    return (boot > OFF) ? boot - OFF : 0;
  endfunction

  // edge index at which clk_en_n falls, counting the ramp start as edge 1
  function automatic int clken_edge(input int boot);
    return 2 + steps_for(boot) * STEP + HOLD;
  endfunction

  function automatic exp_t idle_item(input string tag);
    exp_t e;
    e.tgt = W'(OFF); e.cen = 1'b1; e.pg = 1'b0; e.tag = tag;
    return e;
  endfunction

  function automatic exp_t model(input int m, input int boot, input int drop, input bit late);
    exp_t e;
    int b, th, tw, s;
    if (m - 1 >= drop) return idle_item("R9");
    b  = steps_for(boot);
    th = 2 + b * STEP;
    tw = th + HOLD;
    e.cen = (m >= tw) ? 1'b0 : 1'b1;
    e.pg  = (m >= tw + PG) ? 1'b1 : 1'b0;
    if (m < th) begin
      s = (m - 1) / STEP;
      if (s > b) s = b;
      e.tgt = W'(OFF + s);
      e.tag = (b == 0) ? "R4 R6" : (late ? "R3 R6" : "R2 R6");
    end else if (m <= tw) begin
      e.tgt = W'(OFF + b);
      e.tag = (m == tw) ? "R5" : "R5 R6";
    end else begin
      e.tgt = ext_pat(m - 1);
      e.tag = e.pg ? "R7 R8 R10" : "R7 R10";
    end
    return e;
  endfunction

  task automatic idle_gap(input int k, input string tag);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      en = 1'b0;
      ext_vid = ext_pat(i + 3);
      q.push_back(idle_item(tag));
    end
  endtask

  task automatic run_seq(input int boot, input int boot_late, input int drop, input int extra);
    int len;
    len = clken_edge(boot) + PG + extra;
    boot_code = W'(boot);
    for (int n = 0; n < len; n++) begin
      @(negedge clk);
      en = (n < drop);
      ext_vid = ext_pat(n);
      if (n == 5) boot_code = W'(boot_late);
      q.push_back(model(n + 1, boot, drop, boot_late != boot));
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (target_vid !== e.tgt || clk_en_n !== e.cen || pwr_good !== e.pg) begin
        fails++;
        $display("FAIL %s: got target=%0d clk_en_n=%0b pwr_good=%0b, expected target=%0d clk_en_n=%0b pwr_good=%0b",
                 e.tag, target_vid, clk_en_n, pwr_good, e.tgt, e.cen, e.pg);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: sequence incomplete, got %0d queued, expected 0", q.size());
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state with en low
    idle_gap(4, "R1");
    // R2 R5 R7 R8: full sequence to boot code 12
    run_seq(12, 12, 1 << 30, 8);
    idle_gap(3, "R9");
    // R4: boot code equal to off code
    run_seq(OFF, OFF, 1 << 30, 4);
    idle_gap(3, "R1");
    // R4: boot code below off code
    run_seq(2, 2, 1 << 30, 4);
    idle_gap(3, "R1");
    // R3: boot code changed mid-ramp
    run_seq(20, 50, 1 << 30, 4);
    idle_gap(3, "R1");
    // R9: enable dropped during the ramp, then rerun
    run_seq(30, 30, 20, 0);
    idle_gap(2, "R9");
    // R9: enable dropped while waiting for power-good
    run_seq(12, 12, clken_edge(12) + 5, 0);
    idle_gap(2, "R9");
    // R2: ramp to the top code
    run_seq(127, 127, 1 << 30, 6);
    idle_gap(3, "R9");
    wait (q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule